// File: doc/BRIEF.md
# Split-Access Little-Endian Load/Store Unit

This unit sits between an execution core and a memory that only handles aligned 32-bit words. The core presents one byte-addressed load or store at a time, one, two or four bytes wide, on a 24-bit byte address. The unit turns that request into one or two word transactions on a request/acknowledge memory port. Stores drive a per-lane byte enable so that only the addressed bytes change.

Loads are reassembled in little-endian order, with the lowest address in the least significant byte. Byte and halfword results are then zero- or sign-extended to 32 bits. An access whose bytes run past the end of its word is split. The lower word is accessed first and the following word second. The core sees a single completion pulse.

A split access whose second word would lie past the top of the 16 MB space is not performed. It completes at once with an error flag.

Top module: `lsu_split`

## Requirements
- R1: The first word transaction of a request carries word address `req_addr[23:2]`. `req_addr[1:0]` is the byte lane where the access starts.
- R2: Size encoding: `req_size` 0 is a byte, 1 is a halfword, and 2 or 3 is a full word. A request is split when lane plus byte count exceeds 4. A split request issues exactly two transactions, first at word address A and then at A+1. Any other request issues exactly one.
- R3: A store puts data byte k at byte address `req_addr+k`. Byte address n maps to lane `n[1:0]`, bits `[8*lane+7:8*lane]` of the word at `n[23:2]`. `mem_be` bit `i` is set exactly for the lanes written in that transaction, and all other bytes in memory keep their values.
- R4: A load returns the byte at `req_addr+k` in bits `[8k+7:8k]` of `rdata`. This holds whether or not the load is split.
- R5: A byte or halfword load with `req_signed`=1 fills the upper bits of `rdata` with copies of the top loaded bit. With `req_signed`=0 it fills them with zeros.
- R6: `done` is a one-cycle pulse in the cycle after the last acknowledge. For a load, `rdata` holds the result in that cycle. `busy` is high from the cycle after acceptance until the last acknowledge.
- R7: A request presented while `busy` is high is ignored. It causes no memory transaction and no change in memory.
- R8: A split request at word address 0x3FFFFF issues no memory transaction. `done` and `err` are raised together one cycle after acceptance. A request at that address that is not split completes normally with `err` low.
- R9: After reset, `busy`, `done`, `err` and `mem_req` are all low.
- R10: Once raised, `mem_req` stays high with a stable address, byte enable and direction until `mem_ack` is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe, taken when not busy |
| req_write | input | 1 | 1 = store, 0 = load |
| req_size | input | 2 | 0 byte, 1 halfword, 2/3 word |
| req_signed | input | 1 | Sign-extend narrow loads |
| req_addr | input | 24 | Byte address |
| req_wdata | input | 32 | Store data, right-aligned |
| busy | output | 1 | Request in progress |
| done | output | 1 | Completion pulse |
| err | output | 1 | Wrapping split request, valid with done |
| rdata | output | 32 | Load result, valid with done |
| mem_req | output | 1 | Word transaction request |
| mem_we | output | 1 | Word transaction is a write |
| mem_addr | output | 22 | Word address |
| mem_be | output | 4 | Byte lane enables |
| mem_wdata | output | 32 | Word write data |
| mem_ack | input | 1 | Transaction acknowledge, read data valid |
| mem_rdata | input | 32 | Word read data |

## Verification
The assertions take for granted that memory raises `mem_ack` only while `mem_req` is high, and for exactly one cycle per transaction. Two of them depend on this: the check that a second transaction goes to the next word, and the check that `done` never overlaps an open request. The bench memory acknowledges from a registered wait counter, with a latency of zero to two extra cycles that changes from vector to vector. It never acknowledges in the cycle that follows its own acknowledge. The core side holds `req_valid` for one cycle per request and stays within sizes 0 to 2, except for one deliberate request issued during a busy period.

// File: rtl/lsu_pkg.sv
package lsu_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LOW  = 2'd1,
    ST_HIGH = 2'd2
  } lsu_state_t;

  localparam logic [1:0] SZ_BYTE = 2'd0;
  localparam logic [1:0] SZ_HALF = 2'd1;

  // Number of bytes touched by a request of the given size code.
  function automatic int unsigned lsu_nbytes(input logic [1:0] size,
                                             input int unsigned bytes);
    int unsigned n;
    case (size)
      SZ_BYTE: n = 1;
      SZ_HALF: n = 2;
      default: n = bytes;
    endcase
    if (n > bytes) n = bytes;
    return n;
  endfunction

endpackage

// File: rtl/lsu_lane_map.sv
module lsu_lane_map
  import lsu_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic [$clog2(DATA_W/8)-1:0] off,
  input  logic [1:0]                  size,
  input  logic [DATA_W-1:0]           wdata,
  output logic [DATA_W/8-1:0]         be_lo,
  output logic [DATA_W/8-1:0]         be_hi,
  output logic [DATA_W-1:0]           wd_lo,
  output logic [DATA_W-1:0]           wd_hi,
  output logic                        split
);
  localparam int BYTES = DATA_W / 8;
  localparam int OFF_W = $clog2(BYTES);
  localparam int SUM_W = OFF_W + 2;

  logic [BYTES-1:0]    base_mask;
  logic [2*BYTES-1:0]  wide_mask;
  logic [2*DATA_W-1:0] wide_data;
  logic [SUM_W-1:0]    nb;
  logic [SUM_W-1:0]    reach;

  assign nb = SUM_W'(lsu_nbytes(size, BYTES));

  for (genvar i = 0; i < BYTES; i++) begin : g_mask
    assign base_mask[i] = (SUM_W'(i) < nb);
  end

  assign wide_mask = {{BYTES{1'b0}}, base_mask} << off;
  assign wide_data = {{DATA_W{1'b0}}, wdata} << {off, 3'b000};
  assign reach     = {2'b00, off} + nb;
  assign split     = (reach > SUM_W'(BYTES));

  assign be_lo = wide_mask[BYTES-1:0];
  assign be_hi = wide_mask[2*BYTES-1:BYTES];
  assign wd_lo = wide_data[DATA_W-1:0];
  assign wd_hi = wide_data[2*DATA_W-1:DATA_W];

endmodule

// File: rtl/lsu_read_merge.sv
module lsu_read_merge
  import lsu_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0]           lo_word,
  input  logic [DATA_W-1:0]           hi_word,
  input  logic [$clog2(DATA_W/8)-1:0] off,
  input  logic [1:0]                  size,
  input  logic                        sext,
  output logic [DATA_W-1:0]           result
);
  localparam int BYTES = DATA_W / 8;
  localparam int SUM_W = $clog2(BYTES) + 2;

  logic [2*DATA_W-1:0] joined;
  logic [DATA_W-1:0]   aligned;
  logic [SUM_W-1:0]    nb;
  logic                fill;

  assign joined  = {hi_word, lo_word} >> {off, 3'b000};
  assign aligned = joined[DATA_W-1:0];
  assign nb      = SUM_W'(lsu_nbytes(size, BYTES));

  always_comb begin
    fill = 1'b0;
    for (int b = 0; b < BYTES; b++) begin
      if (SUM_W'(b + 1) == nb) fill = sext & aligned[8*b+7];
    end
  end

  for (genvar i = 0; i < BYTES; i++) begin : g_lane
    assign result[8*i +: 8] = (SUM_W'(i) < nb) ? aligned[8*i +: 8] : {8{fill}};
  end

endmodule

// File: rtl/lsu_seq.sv
module lsu_seq
  import lsu_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int DATA_W = 32
) (
  input  logic                               clk,
  input  logic                               rst,
  input  logic                               req_valid,
  input  logic                               req_write,
  input  logic [ADDR_W-$clog2(DATA_W/8)-1:0] req_waddr,
  input  logic                               split,
  input  logic [DATA_W/8-1:0]                be_lo,
  input  logic [DATA_W/8-1:0]                be_hi,
  input  logic [DATA_W-1:0]                  wd_lo,
  input  logic [DATA_W-1:0]                  wd_hi,
  input  logic                               mem_ack,
  output lsu_state_t                         state,
  output logic                               accept,
  output logic                               reject,
  output logic                               low_ack,
  output logic                               last_ack,
  output logic                               mem_req,
  output logic                               mem_we,
  output logic [ADDR_W-$clog2(DATA_W/8)-1:0] mem_addr,
  output logic [DATA_W/8-1:0]                mem_be,
  output logic [DATA_W-1:0]                  mem_wdata
);
  localparam int BYTES   = DATA_W / 8;
  localparam int WADDR_W = ADDR_W - $clog2(BYTES);

  logic               split_q;
  logic [WADDR_W-1:0] hi_addr_q;
  logic [BYTES-1:0]   hi_be_q;
  logic [DATA_W-1:0]  hi_wd_q;
  logic               wraps;
  logic               acked;

  assign wraps    = &req_waddr;
  assign accept   = (state == ST_IDLE) && req_valid;
  assign reject   = accept && split && wraps;
  assign acked    = mem_req && mem_ack;
  assign low_ack  = acked && (state == ST_LOW);
  assign last_ack = acked && ((state == ST_HIGH) || ((state == ST_LOW) && !split_q));

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      mem_req   <= 1'b0;
      mem_we    <= 1'b0;
      mem_addr  <= '0;
      mem_be    <= '0;
      mem_wdata <= '0;
      split_q   <= 1'b0;
      hi_addr_q <= '0;
      hi_be_q   <= '0;
      hi_wd_q   <= '0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (accept && !reject) begin
            state     <= ST_LOW;
            mem_req   <= 1'b1;
            mem_we    <= req_write;
            mem_addr  <= req_waddr;
            mem_be    <= be_lo;
            mem_wdata <= wd_lo;
            split_q   <= split;
            hi_addr_q <= req_waddr + 1'b1;
            hi_be_q   <= be_hi;
            hi_wd_q   <= wd_hi;
          end
        end
        ST_LOW: begin
          if (acked) begin
            if (split_q) begin
              state     <= ST_HIGH;
              mem_addr  <= hi_addr_q;
              mem_be    <= hi_be_q;
              mem_wdata <= hi_wd_q;
            end else begin
              state   <= ST_IDLE;
              mem_req <= 1'b0;
            end
          end
        end
        ST_HIGH: begin
          if (acked) begin
            state   <= ST_IDLE;
            mem_req <= 1'b0;
          end
        end
        default: begin
          state   <= ST_IDLE;
          mem_req <= 1'b0;
        end
      endcase
    end
  end

endmodule

// File: rtl/lsu_split.sv
module lsu_split
  import lsu_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int DATA_W = 32
) (
  input  logic                               clk,
  input  logic                               rst,
  input  logic                               req_valid,
  input  logic                               req_write,
  input  logic [1:0]                         req_size,
  input  logic                               req_signed,
  input  logic [ADDR_W-1:0]                  req_addr,
  input  logic [DATA_W-1:0]                  req_wdata,
  output logic                               busy,
  output logic                               done,
  output logic                               err,
  output logic [DATA_W-1:0]                  rdata,
  output logic                               mem_req,
  output logic                               mem_we,
  output logic [ADDR_W-$clog2(DATA_W/8)-1:0] mem_addr,
  output logic [DATA_W/8-1:0]                mem_be,
  output logic [DATA_W-1:0]                  mem_wdata,
  input  logic                               mem_ack,
  input  logic [DATA_W-1:0]                  mem_rdata
);
  localparam int BYTES   = DATA_W / 8;
  localparam int OFF_W   = $clog2(BYTES);
  localparam int WADDR_W = ADDR_W - OFF_W;

  logic [OFF_W-1:0]   req_off;
  logic [WADDR_W-1:0] req_waddr;
  logic [BYTES-1:0]   be_lo, be_hi;
  logic [DATA_W-1:0]  wd_lo, wd_hi;
  logic               split;
  lsu_state_t         state;
  logic               accept, reject, low_ack, last_ack;

  logic [OFF_W-1:0]   off_q;
  logic [1:0]         size_q;
  logic               sext_q;
  logic               load_q;
  logic [DATA_W-1:0]  lo_q;
  logic [DATA_W-1:0]  lo_src;
  logic [DATA_W-1:0]  merged;

  assign req_off   = req_addr[OFF_W-1:0];
  assign req_waddr = req_addr[ADDR_W-1:OFF_W];

  lsu_lane_map #(.DATA_W(DATA_W)) u_map (
    .off   (req_off),
    .size  (req_size),
    .wdata (req_wdata),
    .be_lo (be_lo),
    .be_hi (be_hi),
    .wd_lo (wd_lo),
    .wd_hi (wd_hi),
    .split (split)
  );

  lsu_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_seq (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .req_write (req_write),
    .req_waddr (req_waddr),
    .split     (split),
    .be_lo     (be_lo),
    .be_hi     (be_hi),
    .wd_lo     (wd_lo),
    .wd_hi     (wd_hi),
    .mem_ack   (mem_ack),
    .state     (state),
    .accept    (accept),
    .reject    (reject),
    .low_ack   (low_ack),
    .last_ack  (last_ack),
    .mem_req   (mem_req),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .mem_be    (mem_be),
    .mem_wdata (mem_wdata)
  );

  // In the second half of a split load the lower word comes from the holding register.
  assign lo_src = (state == ST_HIGH) ? lo_q : mem_rdata;

  lsu_read_merge #(.DATA_W(DATA_W)) u_merge (
    .lo_word (lo_src),
    .hi_word (mem_rdata),
    .off     (off_q),
    .size    (size_q),
    .sext    (sext_q),
    .result  (merged)
  );

  assign busy = (state != ST_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      off_q  <= '0;
      size_q <= '0;
      sext_q <= 1'b0;
      load_q <= 1'b0;
      lo_q   <= '0;
      rdata  <= '0;
      done   <= 1'b0;
      err    <= 1'b0;
    end else begin
      if (accept) begin
        off_q  <= req_off;
        size_q <= req_size;
        sext_q <= req_signed;
        load_q <= !req_write;
      end
      if (low_ack) lo_q <= mem_rdata;
      if (last_ack && load_q) rdata <= merged;
      done <= last_ack || reject;
      err  <= reject;
    end
  end

endmodule

// File: rtl/lsu_split_chk.sv
module lsu_split_chk #(
  parameter int ADDR_W = 24,
  parameter int DATA_W = 32
) (
  input logic                               clk,
  input logic                               rst,
  input logic                               req_valid,
  input logic                               busy,
  input logic                               done,
  input logic                               err,
  input logic                               mem_req,
  input logic                               mem_ack,
  input logic                               mem_we,
  input logic [ADDR_W-$clog2(DATA_W/8)-1:0] mem_addr,
  input logic [DATA_W/8-1:0]                mem_be
);
  localparam int WADDR_W = ADDR_W - $clog2(DATA_W/8);

  // R10
  hold_req_chk: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_be) && $stable(mem_we)));

  // R2
  next_word_chk: assert property (@(posedge clk) disable iff (rst)
    (mem_req && mem_ack) |=> (!mem_req || (mem_addr == WADDR_W'($past(mem_addr) + 1'b1))));

  // R8
  err_with_done_chk: assert property (@(posedge clk) disable iff (rst)
    err |-> done);

  // R6
  done_idle_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> !mem_req);

  // R6
  req_in_busy_chk: assert property (@(posedge clk) disable iff (rst)
    mem_req |-> busy);

  // R3
  write_lanes_chk: assert property (@(posedge clk) disable iff (rst)
    (mem_req && mem_we) |-> (mem_be != '0));

  // R7
  busy_start_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(req_valid));

endmodule

bind lsu_split lsu_split_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .req_valid (req_valid),
  .busy      (busy),
  .done      (done),
  .err       (err),
  .mem_req   (mem_req),
  .mem_ack   (mem_ack),
  .mem_we    (mem_we),
  .mem_addr  (mem_addr),
  .mem_be    (mem_be)
);

// File: tb/sim_lsu_split.sv
`timescale 1ns/1ps
module sim_lsu_split;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic        req_write = 1'b0;
  logic [1:0]  req_size = 2'd0;
  logic        req_signed = 1'b0;
  logic [23:0] req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic        busy, done, err;
  logic [31:0] rdata;
  logic        mem_req, mem_we;
  logic [21:0] mem_addr;
  logic [3:0]  mem_be;
  logic [31:0] mem_wdata;
  logic        mem_ack;
  logic [31:0] mem_rdata;

  always #10 clk = ~clk;

  lsu_split u0 (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
    .req_size(req_size), .req_signed(req_signed), .req_addr(req_addr),
    .req_wdata(req_wdata), .busy(busy), .done(done), .err(err), .rdata(rdata),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_be(mem_be),
    .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata)
  );

  // Memory model: 16 words, indexed by the low word-address bits.
  logic [31:0] mem [16];
  int          lat = 0;
  int          wcnt = 0;
  always @(posedge clk) begin
    if (rst) begin
      mem_ack   <= 1'b0;
      mem_rdata <= '0;
      wcnt      <= 0;
      for (int i = 0; i < 16; i++) mem[i] <= '0;
    end else begin
      mem_ack <= 1'b0;
      if (mem_req && !mem_ack) begin
        if (wcnt >= lat) begin
          mem_ack   <= 1'b1;
          wcnt      <= 0;
          mem_rdata <= mem[mem_addr[3:0]];
          if (mem_we)
            for (int b = 0; b < 4; b++)
              if (mem_be[b]) mem[mem_addr[3:0]][8*b +: 8] <= mem_wdata[8*b +: 8];
        end else begin
          wcnt <= wcnt + 1;
        end
      end
    end
  end

  // Transaction monitor.
  int          txn = 0;
  logic [21:0] addr0, addr1;
  always @(posedge clk) begin
    if (mem_req && mem_ack) begin
      if (txn == 0) addr0 <= mem_addr;
      else          addr1 <= mem_addr;
      txn <= txn + 1;
    end
  end

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    for (int c = 0; c < 20000; c++) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  // Issue one request and wait for done; returns result, err and transaction count.
  task automatic do_req(input logic wr, input logic [1:0] sz, input logic sg,
                        input logic [23:0] a, input logic [31:0] d,
                        output logic [31:0] rd, output logic er, output int nt,
                        output logic seen);
    @(negedge clk);
    txn = 0;
    req_valid = 1'b1; req_write = wr; req_size = sz; req_signed = sg;
    req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0;
    seen = 1'b0;
    for (int w = 0; w < 50; w++) begin
      if (done) begin seen = 1'b1; break; end
      @(negedge clk);
    end
    rd = rdata; er = err; nt = txn;
  endtask

  typedef struct packed {
    logic        wr;
    logic [1:0]  sz;
    logic        sg;
    logic [23:0] a;
    logic [31:0] d;
    logic [31:0] exp;
    logic [1:0]  nt;
  } vec_t;

  localparam int NV = 14;
  localparam vec_t VEC [NV] = '{
    '{1'b1, 2'd2, 1'b0, 24'h000004, 32'h44332211, 32'h0,        2'd1},
    '{1'b0, 2'd2, 1'b0, 24'h000004, 32'h0,        32'h44332211, 2'd1},
    '{1'b0, 2'd0, 1'b1, 24'h000007, 32'h0,        32'h00000044, 2'd1},
    '{1'b1, 2'd2, 1'b0, 24'h00000A, 32'hDDCCBBAA, 32'h0,        2'd2},
    '{1'b0, 2'd2, 1'b0, 24'h00000A, 32'h0,        32'hDDCCBBAA, 2'd2},
    '{1'b0, 2'd1, 1'b1, 24'h00000B, 32'h0,        32'hFFFFCCBB, 2'd2},
    '{1'b0, 2'd1, 1'b0, 24'h00000B, 32'h0,        32'h0000CCBB, 2'd2},
    '{1'b1, 2'd0, 1'b0, 24'h000009, 32'hFFFFFF80, 32'h0,        2'd1},
    '{1'b0, 2'd0, 1'b1, 24'h000009, 32'h0,        32'hFFFFFF80, 2'd1},
    '{1'b0, 2'd1, 1'b0, 24'h000009, 32'h0,        32'h0000AA80, 2'd1},
    '{1'b1, 2'd1, 1'b0, 24'h00000F, 32'h00001234, 32'h0,        2'd2},
    '{1'b0, 2'd2, 1'b0, 24'h00000C, 32'h0,        32'h3400DDCC, 2'd1},
    '{1'b0, 2'd2, 1'b0, 24'h00000D, 32'h0,        32'h123400DD, 2'd2},
    '{1'b0, 2'd1, 1'b1, 24'h000006, 32'h0,        32'h00004433, 2'd1}
  };

  initial begin
    logic [31:0] rd;
    logic er, seen;
    int nt;

    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R9 reset state
    check("R9 busy", {31'b0, busy}, 32'h0);
    check("R9 done", {31'b0, done}, 32'h0);
    check("R9 err", {31'b0, err}, 32'h0);
    check("R9 mem_req", {31'b0, mem_req}, 32'h0);

    for (int i = 0; i < NV; i++) begin
      lat = i % 3;
      do_req(VEC[i].wr, VEC[i].sz, VEC[i].sg, VEC[i].a, VEC[i].d, rd, er, nt, seen);
      check("R6 done seen", {31'b0, seen}, 32'h1);
      check("R2 transaction count", nt, {30'b0, VEC[i].nt});
      // R1 first word address
      check("R1 first word address", {10'b0, addr0}, {10'b0, VEC[i].a[23:2]});
      if (VEC[i].nt == 2'd2)
        check("R2 second word address", {10'b0, addr1}, {10'b0, VEC[i].a[23:2] + 22'd1});
      check("R8 no error", {31'b0, er}, 32'h0);
      if (!VEC[i].wr) begin
        if (VEC[i].sz != 2'd2)
          check(VEC[i].sg ? "R5 signed load" : "R5 unsigned load", rd, VEC[i].exp);
        else
          check("R4 word load", rd, VEC[i].exp);
      end
      @(negedge clk);
      check("R6 done single pulse", {31'b0, done}, 32'h0);
    end

    // R3 direct memory contents after the split writes
    check("R3 word 2 lanes", mem[2], 32'hBBAA8000);
    check("R3 word 3 lanes", mem[3], 32'h3400DDCC);
    check("R3 word 4 lanes", mem[4], 32'h00000012);

    // R7 request while busy is ignored
    lat = 4;
    @(negedge clk);
    txn = 0;
    req_valid = 1'b1; req_write = 1'b1; req_size = 2'd2; req_addr = 24'h000000;
    req_wdata = 32'h55667788;
    @(negedge clk);
    check("R6 busy after accept", {31'b0, busy}, 32'h1);
    req_addr = 24'h000020; req_wdata = 32'hFFFFFFFF; req_size = 2'd3;
    @(negedge clk);
    req_valid = 1'b0;
    for (int w = 0; w < 50; w++) begin
      if (done) break;
      @(negedge clk);
    end
    check("R7 one transaction", txn, 32'd1);
    repeat (3) @(negedge clk);
    check("R7 no second transaction", txn, 32'd1);
    lat = 0;
    do_req(1'b0, 2'd2, 1'b0, 24'h000020, 32'h0, rd, er, nt, seen);
    check("R7 ignored store left word 8", rd, 32'h00000000);
    do_req(1'b0, 2'd2, 1'b0, 24'h000000, 32'h0, rd, er, nt, seen);
    check("R7 accepted store", rd, 32'h55667788);

    // R8 wrapping split request
    do_req(1'b0, 2'd2, 1'b0, 24'hFFFFFE, 32'h0, rd, er, nt, seen);
    check("R8 done", {31'b0, seen}, 32'h1);
    check("R8 err", {31'b0, er}, 32'h1);
    check("R8 no transaction", nt, 32'd0);
    do_req(1'b1, 2'd1, 1'b0, 24'hFFFFFF, 32'h0000ABCD, rd, er, nt, seen);
    check("R8 wrapping store err", {31'b0, er}, 32'h1);
    check("R8 wrapping store no transaction", nt, 32'd0);
    // R8 top byte, not split
    do_req(1'b0, 2'd0, 1'b0, 24'hFFFFFF, 32'h0, rd, er, nt, seen);
    check("R8 top byte no err", {31'b0, er}, 32'h0);
    check("R8 top byte one transaction", nt, 32'd1);
    check("R1 top word address", {10'b0, addr0}, 32'h003FFFFF);
    check("R4 top byte data", rd, 32'h00000000);

    finish_run();
  end

endmodule